// File: doc/BRIEF.md
# ADC Sequencing Register Block

This block is the device-side register file of a byte-wide, port-mapped analog I/O card. A host reaches it through a small address window. Single-byte accesses are used for the control-type registers, and 16-bit accesses for the data words. The block stores the ADC channel range, the trigger source, and the gain, polarity and bank fields. It also holds a bank of DAC output words and reports conversion status.

A software strobe starts an ADC conversion. The busy flag then stays set for a frame time. That time comes from a frame count taken at the moment of the strobe, with every frame lasting a fixed number of clock ticks. When busy clears, the block latches the value on its sample input port, which stands in for the analog converter. From then on a read of the data offset returns that value.

A three-step unlock pattern, written into the upper nibble of the configuration register, switches the card over to its counter/timer bank.

Top module: `aio_seq_regs`

## Requirements
- R1: After a synchronous reset, the following hold: busy is 0; the control register reads 0; the configuration register reads 0 (gain code 0 = x1, bit 2 = 0 = bipolar, bank nibble 0); every DAC word reads 0; `timer_bank_sel` is 0.
- R2: The channel register at offset 0x02 takes any byte. It reads back unchanged. Bits 3:0 drive `chan_first` and bits 7:4 drive `chan_last`.
- R3: The control register at offset 0x09 keeps bits 1:0 as the trigger source and reads the other bits as 0. A strobe starts a conversion only while this field is 0 (software trigger). With any other value, a strobe leaves busy at 0.
- R4: The configuration register at offset 0x11 reads back the byte last written. Bits 1:0 drive `adc_gain` (0=x1, 1=x2, 2=x4, 3=x8). Bit 2 drives `adc_unipolar` (0 = bipolar, 1 = unipolar).
- R5: A write of any value and any width to offset 0x00 while idle, under software trigger, sets busy on the same clock edge.
- R6: Let F be the `frame_count` value sampled on the strobe edge. Busy then stays high for exactly (F+1)*TICKS_PER_FRAME cycles. Later changes to `frame_count` have no effect on a conversion already running.
- R7: A strobe that arrives while busy is set is ignored. It neither extends nor restarts the running conversion.
- R8: `sample_in` is captured on the edge where busy clears. A read of offset 0x00 returns the last captured sample, and during a conversion it still returns the previous one.
- R9: The status register at offset 0x08 reads busy on bit 7 and `strap_diff` on bit 5. All its other bits read 0.
- R10: The DAC words sit at offsets 0x04 and 0x06 (0x04 + 2*i). They change only on 16-bit writes, which load the full `bus_wdata`, and read back as 16-bit values. Byte writes to them have no effect.
- R11: Three consecutive configuration writes whose bits 7:4 are 0x3, 0xB, 0xA set `timer_bank_sel`. It stays set until reset. Writes to other offsets do not break the pattern.
- R12: A configuration write that breaks the pattern or puts it out of order restarts detection, and `timer_bank_sel` stays 0. A nibble of 0x3 always counts as a fresh first step.
- R13: Reads of any offset not named above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | DATA_W | Write data (byte registers use bits 7:0) |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| strap_diff | input | 1 | Input strapping: 1 = differential, 0 = single-ended |
| frame_count | input | FRAME_W | Frame count sampled at each accepted strobe |
| sample_in | input | DATA_W | Converter result standing in for the analog path |
| adc_busy | output | 1 | Conversion in progress |
| chan_first | output | 4 | First channel of the scan range |
| chan_last | output | 4 | Last channel of the scan range |
| adc_gain | output | 2 | Gain code to the front end |
| adc_unipolar | output | 1 | Input range polarity select |
| timer_bank_sel | output | 1 | Counter/timer bank selected |
| dac_out | output | NUM_DAC*DAC_W... see DATA_W | DAC words, word i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest case to reach from the ports is a strobe that lands in the middle of a running conversion. The bench handles it by driving the write strobe directly from inside its busy-counting loop, on the third busy cycle. It then confirms that the busy length measured from the first strobe still matches (F+1) frames. The same loop also changes `sample_in` and `frame_count` once the conversion has started. This shows that the count is taken at the strobe and that the sample is taken only at completion. Unlock detection is driven with broken, reordered and restarted nibble patterns before the one valid pattern, so that an early false match would show up as `timer_bank_sel` going high too soon.

// File: rtl/aio_pkg.sv
package aio_pkg;

    // Register offsets; the host software decodes these positions.
    localparam int OFS_DATA = 'h00;
    localparam int OFS_CHAN = 'h02;
    localparam int OFS_DAC0 = 'h04;
    localparam int DAC_STEP = 2;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_CTRL = 'h09;
    localparam int OFS_CFG  = 'h11;

    // Unlock pattern for the bank nibble, in order.
    localparam logic [3:0] UNLK_1 = 4'h3;
    localparam logic [3:0] UNLK_2 = 4'hB;
    localparam logic [3:0] UNLK_3 = 4'hA;

    localparam logic [1:0] TRIG_SOFT = 2'd0;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_GOT1,
        UL_GOT2
    } unlock_st_t;

    typedef struct packed {
        logic [3:0] bank;
        logic       spare;
        logic       unipolar;
        logic [1:0] gain;
    } cfg_t;

    typedef struct packed {
        logic [3:0] last;
        logic [3:0] first;
    } chan_t;

    typedef struct packed {
        logic strobe;
        logic chan;
        logic ctrl;
        logic cfg;
    } wr_sel_t;

    function automatic logic [7:0] status_byte(logic busy, logic diff);
        return {busy, 1'b0, diff, 5'b0};
    endfunction

endpackage

// File: rtl/aio_wr_decode.sv
module aio_wr_decode
    import aio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int NUM_DAC = 2
) (
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_sel_t           sel,
    output logic [NUM_DAC-1:0] dac_we
);

    always_comb begin
        sel.strobe = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
        sel.chan   = bus_wr && (bus_addr == ADDR_W'(OFS_CHAN));
        sel.ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        sel.cfg    = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    end

    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac_dec
        assign dac_we[i] = bus_wr && bus_wide
                           && (bus_addr == ADDR_W'(OFS_DAC0 + DAC_STEP * i));
    end

endmodule

// File: rtl/aio_frame_timer.sv
module aio_frame_timer #(
    parameter int FRAME_W         = 32,
    parameter int TICKS_PER_FRAME = 5,
    parameter int DATA_W          = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_count,
    input  logic [DATA_W-1:0]  sample_in,
    output logic               busy,
    output logic [DATA_W-1:0]  sample_q
);

    localparam int TICK_W = (TICKS_PER_FRAME > 1) ? $clog2(TICKS_PER_FRAME) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_FRAME - 1);

    logic [FRAME_W-1:0] frames_left;
    logic [TICK_W-1:0]  tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            frames_left <= '0;
            tick        <= '0;
            sample_q    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy        <= 1'b1;
                frames_left <= frame_count;
                tick        <= TICK_LAST;
            end
        end else if (tick != '0) begin
            tick <= tick - 1'b1;
        end else if (frames_left != '0) begin
            frames_left <= frames_left - 1'b1;
            tick        <= TICK_LAST;
        end else begin
            busy     <= 1'b0;
            sample_q <= sample_in;
        end
    end

endmodule

// File: rtl/aio_unlock_fsm.sv
module aio_unlock_fsm
    import aio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [3:0] nibble,
    output logic       timer_bank
);

    unlock_st_t st_q, st_d;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (cfg_we) begin
            st_d = (nibble == UNLK_1) ? UL_GOT1 : UL_IDLE;
            case (st_q)
                UL_GOT1: if (nibble == UNLK_2) st_d = UL_GOT2;
                UL_GOT2: if (nibble == UNLK_3) begin
                    hit  = 1'b1;
                    st_d = UL_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= UL_IDLE;
            timer_bank <= 1'b0;
        end else begin
            st_q <= st_d;
            if (hit) timer_bank <= 1'b1;
        end
    end

endmodule

// File: rtl/aio_seq_regs.sv
module aio_seq_regs
    import aio_pkg::*;
#(
    parameter int ADDR_W          = 5,
    parameter int DATA_W          = 16,
    parameter int FRAME_W         = 32,
    parameter int TICKS_PER_FRAME = 5,
    parameter int NUM_DAC         = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_wide,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      strap_diff,
    input  logic [FRAME_W-1:0]        frame_count,
    input  logic [DATA_W-1:0]         sample_in,
    output logic                      adc_busy,
    output logic [3:0]                chan_first,
    output logic [3:0]                chan_last,
    output logic [1:0]                adc_gain,
    output logic                      adc_unipolar,
    output logic                      timer_bank_sel,
    output logic [NUM_DAC*DATA_W-1:0] dac_out
);

    wr_sel_t              sel;
    logic [NUM_DAC-1:0]   dac_we;
    chan_t                chan_q;
    logic [1:0]           ctrl_q;
    cfg_t                 cfg_q;
    logic [DATA_W-1:0]    dac_q [NUM_DAC];
    logic [DATA_W-1:0]    sample_q;
    logic                 conv_start;

    aio_wr_decode #(.ADDR_W(ADDR_W), .NUM_DAC(NUM_DAC)) u_dec (
        .bus_wr   (bus_wr),
        .bus_wide (bus_wide),
        .bus_addr (bus_addr),
        .sel      (sel),
        .dac_we   (dac_we)
    );

    assign conv_start = sel.strobe && (ctrl_q == TRIG_SOFT);

    aio_frame_timer #(
        .FRAME_W(FRAME_W), .TICKS_PER_FRAME(TICKS_PER_FRAME), .DATA_W(DATA_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (conv_start),
        .frame_count (frame_count),
        .sample_in   (sample_in),
        .busy        (adc_busy),
        .sample_q    (sample_q)
    );

    aio_unlock_fsm u_unlock (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (sel.cfg),
        .nibble     (bus_wdata[7:4]),
        .timer_bank (timer_bank_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            ctrl_q <= TRIG_SOFT;
            cfg_q  <= '0;
            for (int i = 0; i < NUM_DAC; i++) dac_q[i] <= '0;
        end else begin
            if (sel.chan) chan_q <= chan_t'(bus_wdata[7:0]);
            if (sel.ctrl) ctrl_q <= bus_wdata[1:0];
            if (sel.cfg)  cfg_q  <= cfg_t'(bus_wdata[7:0]);
            for (int i = 0; i < NUM_DAC; i++) begin
                if (dac_we[i]) dac_q[i] <= bus_wdata;
            end
        end
    end

    assign chan_first   = chan_q.first;
    assign chan_last    = chan_q.last;
    assign adc_gain     = cfg_q.gain;
    assign adc_unipolar = cfg_q.unipolar;

    for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac_out
        assign dac_out[i*DATA_W +: DATA_W] = dac_q[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_DATA))      bus_rdata = sample_q;
        else if (bus_addr == ADDR_W'(OFS_CHAN)) bus_rdata = DATA_W'(chan_q);
        else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = DATA_W'(status_byte(adc_busy, strap_diff));
        else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = DATA_W'(ctrl_q);
        else if (bus_addr == ADDR_W'(OFS_CFG))  bus_rdata = DATA_W'(cfg_q);
        for (int i = 0; i < NUM_DAC; i++) begin
            if (bus_addr == ADDR_W'(OFS_DAC0 + DAC_STEP * i)) bus_rdata = dac_q[i];
        end
    end

endmodule

// File: rtl/aio_seq_regs_chk.sv
module aio_seq_regs_chk
    import aio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int NUM_DAC = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr,
    input logic                      bus_wide,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      strap_diff,
    input logic                      adc_busy,
    input logic [1:0]                trig,
    input logic [DATA_W-1:0]         sample_q,
    input logic                      timer_bank_sel,
    input logic [NUM_DAC*DATA_W-1:0] dac_out
);

    logic strobe_wr;
    assign strobe_wr = bus_wr && (bus_addr == ADDR_W'(OFS_DATA)) && !adc_busy;

    // R9
    p_status_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OFS_STAT)) |-> (bus_rdata[7] == adc_busy && bus_rdata[5] == strap_diff));

    // R5
    p_strobe_starts_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe_wr && trig == TRIG_SOFT) |=> adc_busy);

    // R3
    p_trig_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe_wr && trig != TRIG_SOFT) |=> !adc_busy);

    // R8
    p_sample_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_q) |-> $fell(adc_busy));

    // R11
    p_bank_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        timer_bank_sel |=> timer_bank_sel);

    // R10
    p_dac_byte_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_wide && bus_addr == ADDR_W'(OFS_DAC0)) |=> $stable(dac_out));

endmodule

bind aio_seq_regs aio_seq_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wide       (bus_wide),
    .bus_rdata      (bus_rdata),
    .strap_diff     (strap_diff),
    .adc_busy       (adc_busy),
    .trig           (ctrl_q),
    .sample_q       (sample_q),
    .timer_bank_sel (timer_bank_sel),
    .dac_out        (dac_out)
);

// File: tb/aio_seq_regs_tb_top.sv
module aio_seq_regs_tb_top;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int FRAME_W = 32;
    localparam int TICKS = 5;
    localparam int NUM_DAC = 2;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [ADDR_W-1:0]         bus_addr = '0;
    logic                      bus_wr = 1'b0;
    logic                      bus_wide = 1'b0;
    logic [DATA_W-1:0]         bus_wdata = '0;
    logic [DATA_W-1:0]         bus_rdata;
    logic                      strap_diff = 1'b0;
    logic [FRAME_W-1:0]        frame_count = '0;
    logic [DATA_W-1:0]         sample_in = '0;
    logic                      adc_busy;
    logic [3:0]                chan_first, chan_last;
    logic [1:0]                adc_gain;
    logic                      adc_unipolar;
    logic                      timer_bank_sel;
    logic [NUM_DAC*DATA_W-1:0] dac_out;

    int n_checks = 0;
    int n_errs = 0;

    always #2.5 clk = ~clk;

    aio_seq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W),
        .TICKS_PER_FRAME(TICKS), .NUM_DAC(NUM_DAC)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_diff(strap_diff),
        .frame_count(frame_count), .sample_in(sample_in), .adc_busy(adc_busy),
        .chan_first(chan_first), .chan_last(chan_last), .adc_gain(adc_gain),
        .adc_unipolar(adc_unipolar), .timer_bank_sel(timer_bank_sel), .dac_out(dac_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d, input bit wide);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wide = wide; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 v = bus_rdata;
    endtask

    // One conversion with frame count f; expects val captured at the end.
    task automatic conv(input int f, input logic [15:0] val, input bit inject);
        logic [15:0] prev, v;
        int cnt;
        rd(0, prev);
        frame_count = FRAME_W'(f);
        sample_in = ~val;
        @(negedge clk);
        bus_addr = '0; bus_wdata = 16'h00A5; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        frame_count = 32'h0000_0FFF;
        chk("R5 busy after strobe", adc_busy, 1);
        cnt = 0;
        while (adc_busy && cnt < 5000) begin
            cnt++;
            if (cnt == 1) begin
                chk("R8 old sample held while busy", bus_rdata, prev);
                sample_in = val;
            end
            bus_wr = inject && (cnt == 3);
            @(negedge clk);
        end
        bus_wr = 1'b0;
        if (inject) chk("R7 busy length with extra strobe", cnt, (f + 1) * TICKS);
        else        chk("R6 busy length", cnt, (f + 1) * TICKS);
        rd(0, v);
        chk("R8 captured sample", v, val);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", adc_busy, 0);
        rd(9, v);  chk("R1 control", v, 0);
        rd(17, v); chk("R1 config", v, 0);
        rd(4, v);  chk("R1 dac0", v, 0);
        rd(6, v);  chk("R1 dac1", v, 0);
        chk("R1 bank", timer_bank_sel, 0);
        chk("R1 gain", adc_gain, 0);
        chk("R1 polarity", adc_unipolar, 0);

        // R9 status register
        for (int s = 0; s < 2; s++) begin
            strap_diff = s[0];
            rd(8, v);
            chk("R9 status", v, {8'h00, 2'b00, s[0], 5'b0});
        end
        strap_diff = 1'b0;

        // R2 channel register sweep
        for (int c = 0; c < 256; c++) begin
            wr(2, 16'(c), 1'b0);
            rd(2, v);
            chk("R2 readback", v, 32'(c));
            chk("R2 first", chan_first, c % 16);
            chk("R2 last", chan_last, c / 16);
        end

        // R4 configuration low nibble sweep
        for (int g = 0; g < 16; g++) begin
            wr(17, 16'(g), 1'b0);
            rd(17, v);
            chk("R4 readback", v, 32'(g));
            chk("R4 gain", adc_gain, g % 4);
            chk("R4 polarity", adc_unipolar, (g / 4) % 2);
        end

        // R3 control register and trigger gate
        wr(9, 16'h00FD, 1'b0);
        rd(9, v); chk("R3 control keeps bits 1:0", v, 1);
        wr(0, 16'h0000, 1'b0);
        chk("R3 no start on hardware trigger", adc_busy, 0);
        @(negedge clk);
        chk("R3 still idle", adc_busy, 0);
        wr(9, 16'h0000, 1'b0);

        // R5..R8 conversions over a span of frame counts
        for (int f = 0; f < 8; f++) conv(f, 16'h1000 + 16'(f * 37), 1'b0);
        conv(20, 16'hBEEF, 1'b0);
        conv(0, 16'h0001, 1'b1);
        conv(3, 16'hFFFF, 1'b1);
        conv(12, 16'h8000, 1'b1);

        // R10 DAC words
        for (int i = 0; i < NUM_DAC; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] d;
                d = 16'(16'h1234 * (k + 1) + i * 16'h0F0F);
                wr(4 + 2 * i, d, 1'b1);
                rd(4 + 2 * i, v);
                chk("R10 dac readback", v, d);
                chk("R10 dac port", dac_out[i*DATA_W +: DATA_W], d);
            end
        end
        rd(4, v);
        wr(4, 16'h0055, 1'b0);
        begin
            logic [15:0] v2;
            rd(4, v2);
            chk("R10 byte write ignored", v2, v);
            chk("R10 byte write port", dac_out[15:0], v);
        end

        // R13 unmapped offsets
        for (int a = 0; a < 32; a++) begin
            if (!(a == 0 || a == 2 || a == 4 || a == 6 || a == 8 || a == 9 || a == 17)) begin
                rd(a, v);
                chk("R13 unmapped read", v, 0);
            end
        end

        // R12 broken and reordered patterns (low bits 0x6 = gain x4, unipolar)
        wr(17, 16'h0036, 1'b0); wr(17, 16'h00B6, 1'b0);
        wr(17, 16'h0056, 1'b0); wr(17, 16'h00A6, 1'b0);
        chk("R12 interrupted pattern", timer_bank_sel, 0);
        wr(17, 16'h00B6, 1'b0); wr(17, 16'h0036, 1'b0); wr(17, 16'h00A6, 1'b0);
        chk("R12 reordered pattern", timer_bank_sel, 0);
        wr(17, 16'h0036, 1'b0); wr(17, 16'h00A6, 1'b0); wr(17, 16'h00B6, 1'b0);
        chk("R12 swapped tail", timer_bank_sel, 0);

        // R11 restart on repeated first step, other offsets between writes
        wr(17, 16'h0036, 1'b0); wr(17, 16'h0036, 1'b0);
        wr(17, 16'h00B6, 1'b0);
        wr(2, 16'h0011, 1'b0);
        chk("R11 not yet selected", timer_bank_sel, 0);
        wr(17, 16'h00A6, 1'b0);
        chk("R11 selected", timer_bank_sel, 1);
        chk("R11 gain kept", adc_gain, 2);
        chk("R11 polarity kept", adc_unipolar, 1);
        wr(17, 16'h0000, 1'b0);
        chk("R11 sticky", timer_bank_sel, 1);

        // R1 reset clears selection and configuration
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R1 bank after reset", timer_bank_sel, 0);
        rd(17, v); chk("R1 config after reset", v, 0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule